// File: doc/BRIEF.md
# Compare-Branch Fusing Instruction Decoder

This decode-stage block receives a window of up to five pre-classified instructions each cycle. Every window entry carries a valid bit, a two-bit class and an opaque payload. The block steers the window into four decoder slots and produces internal micro-operations in program order. Where a compare or a test instruction is directly followed by a conditional jump, the two are merged into one fused micro-operation that carries both payloads. Only one such merge is allowed per cycle, so a full cycle can retire five instructions into four micro-operations.

The number of window entries taken is reported combinationally in the same cycle, so the fetch side can shift its window before the next edge. The micro-operations and their count are registered and appear after the clock edge that consumed them. When the downstream side is not ready, nothing is taken and the registered outputs keep their values.

Top module: `fuse_decoder`

## Requirements
- R1: The window is the run of entries from position 0 up to, but not including, the first entry whose valid bit is 0. Entries after that first invalid entry are ignored whatever their valid bits or classes are.
- R2: Class codes are 0 = other, 1 = compare, 2 = test, 3 = conditional jump. An instruction that is not fused becomes one micro-op with fused = 0, its own class, payload A equal to its payload and payload B equal to 0. Micro-ops fill slots from slot 0 in program order. Slots beyond the emitted count have every field equal to 0.
- R3: At most one pair is fused per cycle. When several fusible pairs are taken, only the earliest one in program order is fused, and every later instruction is decoded unfused.
- R4: A compare or a test that is directly followed by a conditional jump inside the window forms one micro-op. That micro-op has fused = 1, the class of the compare or test, payload A taken from the compare or test, and payload B taken from the jump. This fused micro-op may occupy any slot from 0 to 3.
- R5: `take_cnt` gives the number of window entries consumed, from 0 to 5. `uop_cnt` gives the number of micro-ops emitted, from 0 to 4. The count of micro-ops equals the count of consumed entries minus the number of fused micro-ops. Without a fusion, min(window length, 4) entries are taken. With a fusion, the whole window is taken.
- R6: A compare or a test in the last position of the window is decoded unfused.
- R7: While `dn_ready` is 0, `take_cnt` is 0 and all registered micro-op outputs and `uop_cnt` hold their values across clock edges.
- R8: While `rst` is high, at the clock edge every micro-op output and `uop_cnt` are cleared to 0.
- R9: `take_cnt` reflects the current window in the same cycle. The micro-ops for that window appear on the outputs after the next rising edge at which `dn_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_valid | input | WIN | Per-entry valid bits, entry 0 oldest |
| win_cls | input | WIN x 2 | Per-entry class code |
| win_pay | input | WIN x PAY_W | Per-entry payload |
| dn_ready | input | 1 | Downstream accepts micro-ops this cycle |
| take_cnt | output | clog2(WIN+1) | Entries consumed this cycle |
| uop_valid | output | SLOTS | Registered slot valid bits |
| uop_fused | output | SLOTS | Registered fused flags |
| uop_cls | output | SLOTS x 2 | Registered class of the slot's first instruction |
| uop_pay_a | output | SLOTS x PAY_W | Registered first payload |
| uop_pay_b | output | SLOTS x PAY_W | Registered jump payload, 0 when unfused |
| uop_cnt | output | clog2(SLOTS+1) | Registered number of micro-ops |

## Verification
The bench sweeps every combination of the four classes across the five entries at every window length from 0 to 5. This exposes each position of a fusible pair, including a pair whose compare sits in slot 3. It also covers windows holding two or more pairs, which separate an earliest-pair rule from a last-pair rule or a fuse-all rule. A compare or test that sits at the end of the window shows whether fusion looks past the valid prefix. Garbage beyond the first invalid entry on odd patterns shows whether it leaks in. Interleaved stall cycles with a different window show whether anything is taken or any output moves while the downstream side is not ready.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    localparam int PAY_W = 16;

    typedef enum logic [1:0] {
        IC_OTHER = 2'd0,
        IC_CMP   = 2'd1,
        IC_TEST  = 2'd2,
        IC_JCC   = 2'd3
    } iclass_e;

    typedef struct packed {
        logic             valid;
        iclass_e          cls;
        logic [PAY_W-1:0] pay;
    } inst_t;

    typedef struct packed {
        logic             valid;
        logic             fused;
        iclass_e          cls;
        logic [PAY_W-1:0] pay_a;
        logic [PAY_W-1:0] pay_b;
    } uop_t;

    function automatic logic sets_flags(iclass_e c);
        return (c == IC_CMP) || (c == IC_TEST);
    endfunction

    function automatic logic reads_flags(iclass_e c);
        return c == IC_JCC;
    endfunction

endpackage

// File: rtl/fuse_pair_detect.sv
module fuse_pair_detect
    import fuse_pkg::*;
#(
    parameter int WIN = 5
) (
    input  inst_t [WIN-1:0] win,
    output logic  [WIN-1:0] pair_ok
);

    // A pair may start at any position that has a successor in the window.
    for (genvar p = 0; p < WIN; p++) begin : g_pos
        if (p < WIN - 1) begin : g_has_next
            assign pair_ok[p] = win[p].valid && sets_flags(win[p].cls)
                              && win[p+1].valid && reads_flags(win[p+1].cls);
        end else begin : g_last
            assign pair_ok[p] = 1'b0;
        end
    end

endmodule

// File: rtl/fuse_slot_steer.sv
module fuse_slot_steer
    import fuse_pkg::*;
#(
    parameter int WIN   = 5,
    parameter int SLOTS = 4,
    localparam int CNT_W  = $clog2(WIN + 1),
    localparam int SCNT_W = $clog2(SLOTS + 1)
) (
    input  inst_t [WIN-1:0]   win,
    input  logic  [WIN-1:0]   pair_ok,
    output uop_t  [SLOTS-1:0] uops,
    output logic  [SLOTS-1:0] fused_vec,
    output logic  [CNT_W-1:0] take,
    output logic  [SCNT_W-1:0] nuop
);

    localparam int POS_W = $clog2(WIN + 2);

    logic [POS_W-1:0] pos;
    logic             done;
    logic             used;

    always_comb begin
        uops      = '0;
        fused_vec = '0;
        take      = '0;
        nuop      = '0;
        pos       = '0;
        done      = 1'b0;
        used      = 1'b0;
        for (int s = 0; s < SLOTS; s++) begin
            if (!done) begin
                if (pos >= POS_W'(WIN)) begin
                    done = 1'b1;
                end else if (!win[pos].valid) begin
                    done = 1'b1;
                end else if (pair_ok[pos] && !used) begin
                    uops[s].valid = 1'b1;
                    uops[s].fused = 1'b1;
                    uops[s].cls   = win[pos].cls;
                    uops[s].pay_a = win[pos].pay;
                    uops[s].pay_b = win[pos + POS_W'(1)].pay;
                    fused_vec[s]  = 1'b1;
                    used          = 1'b1;
                    pos           = pos + POS_W'(2);
                    take          = take + CNT_W'(2);
                    nuop          = nuop + SCNT_W'(1);
                end else begin
                    uops[s].valid = 1'b1;
                    uops[s].cls   = win[pos].cls;
                    uops[s].pay_a = win[pos].pay;
                    pos           = pos + POS_W'(1);
                    take          = take + CNT_W'(1);
                    nuop          = nuop + SCNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/fuse_uop_reg.sv
module fuse_uop_reg
    import fuse_pkg::*;
#(
    parameter int SLOTS = 4,
    localparam int SCNT_W = $clog2(SLOTS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  uop_t  [SLOTS-1:0]  uops_d,
    input  logic  [SCNT_W-1:0] nuop_d,
    output uop_t  [SLOTS-1:0]  uops_q,
    output logic  [SCNT_W-1:0] nuop_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            uops_q <= '0;
            nuop_q <= '0;
        end else if (load) begin
            uops_q <= uops_d;
            nuop_q <= nuop_d;
        end
    end

    logic [SLOTS-1:0] vq;
    logic [SLOTS-1:0] fq;
    for (genvar g = 0; g < SLOTS; g++) begin : g_bits
        assign vq[g] = uops_q[g].valid;
        assign fq[g] = uops_q[g].fused;
    end

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load)) |-> ($stable(uops_q) && $stable(nuop_q)));

    assert_prefix_R2: assert property (@(posedge clk) disable iff (rst)
        vq == ((SLOTS'(1) << nuop_q) - SLOTS'(1)));

    assert_fused_valid_R4: assert property (@(posedge clk) disable iff (rst)
        (fq & ~vq) == '0);

    assert_single_fuse_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fq));

    assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (nuop_q == '0 && vq == '0));

endmodule

// File: rtl/fuse_decoder.sv
module fuse_decoder
    import fuse_pkg::*;
#(
    parameter int WIN   = 5,
    parameter int SLOTS = 4,
    localparam int CNT_W  = $clog2(WIN + 1),
    localparam int SCNT_W = $clog2(SLOTS + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [WIN-1:0]               win_valid,
    input  logic [WIN-1:0][1:0]          win_cls,
    input  logic [WIN-1:0][PAY_W-1:0]    win_pay,
    input  logic                         dn_ready,
    output logic [CNT_W-1:0]             take_cnt,
    output logic [SLOTS-1:0]             uop_valid,
    output logic [SLOTS-1:0]             uop_fused,
    output logic [SLOTS-1:0][1:0]        uop_cls,
    output logic [SLOTS-1:0][PAY_W-1:0]  uop_pay_a,
    output logic [SLOTS-1:0][PAY_W-1:0]  uop_pay_b,
    output logic [SCNT_W-1:0]            uop_cnt
);

    inst_t [WIN-1:0]   win;
    logic  [WIN-1:0]   pair_ok;
    uop_t  [SLOTS-1:0] uops_d;
    uop_t  [SLOTS-1:0] uops_q;
    logic  [SLOTS-1:0] fused_vec;
    logic  [CNT_W-1:0] take_raw;
    logic  [SCNT_W-1:0] nuop_raw;

    for (genvar g = 0; g < WIN; g++) begin : g_pack
        assign win[g].valid = win_valid[g];
        assign win[g].cls   = iclass_e'(win_cls[g]);
        assign win[g].pay   = win_pay[g];
    end

    fuse_pair_detect #(.WIN(WIN)) i_detect (
        .win     (win),
        .pair_ok (pair_ok)
    );

    fuse_slot_steer #(.WIN(WIN), .SLOTS(SLOTS)) i_steer (
        .win       (win),
        .pair_ok   (pair_ok),
        .uops      (uops_d),
        .fused_vec (fused_vec),
        .take      (take_raw),
        .nuop      (nuop_raw)
    );

    fuse_uop_reg #(.SLOTS(SLOTS)) i_oreg (
        .clk    (clk),
        .rst    (rst),
        .load   (dn_ready),
        .uops_d (uops_d),
        .nuop_d (nuop_raw),
        .uops_q (uops_q),
        .nuop_q (uop_cnt)
    );

    assign take_cnt = dn_ready ? take_raw : '0;

    for (genvar g = 0; g < SLOTS; g++) begin : g_unpack
        assign uop_valid[g] = uops_q[g].valid;
        assign uop_fused[g] = uops_q[g].fused;
        assign uop_cls[g]   = uops_q[g].cls;
        assign uop_pay_a[g] = uops_q[g].pay_a;
        assign uop_pay_b[g] = uops_q[g].pay_b;
    end

    assert_take_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (take_raw <= CNT_W'(WIN)) && (nuop_raw <= SCNT_W'(SLOTS)));

    assert_fuse_gain_R5: assert property (@(posedge clk) disable iff (rst)
        32'(take_raw) == 32'(nuop_raw) + $countones(fused_vec));

    assert_one_pair_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fused_vec));

    assert_count_link_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(dn_ready)) |->
            32'(uop_cnt) == 32'($past(take_cnt)) - $countones(uop_fused));

endmodule

// File: tb/test_fuse_decoder.sv
module test_fuse_decoder;
    import fuse_pkg::*;

    localparam int WIN = 5;
    localparam int SLOTS = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [WIN-1:0] win_valid = '0;
    logic [WIN-1:0][1:0] win_cls = '0;
    logic [WIN-1:0][PAY_W-1:0] win_pay = '0;
    logic dn_ready = 1'b0;
    logic [2:0] take_cnt;
    logic [SLOTS-1:0] uop_valid;
    logic [SLOTS-1:0] uop_fused;
    logic [SLOTS-1:0][1:0] uop_cls;
    logic [SLOTS-1:0][PAY_W-1:0] uop_pay_a;
    logic [SLOTS-1:0][PAY_W-1:0] uop_pay_b;
    logic [2:0] uop_cnt;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    fuse_decoder #(.WIN(WIN), .SLOTS(SLOTS)) i_fuse_decoder (
        .clk(clk), .rst(rst), .win_valid(win_valid), .win_cls(win_cls),
        .win_pay(win_pay), .dn_ready(dn_ready), .take_cnt(take_cnt),
        .uop_valid(uop_valid), .uop_fused(uop_fused), .uop_cls(uop_cls),
        .uop_pay_a(uop_pay_a), .uop_pay_b(uop_pay_b), .uop_cnt(uop_cnt)
    );

    task automatic check(string req, string what, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [37:0] slot_word(int k);
        return {uop_valid[k], uop_fused[k], uop_cls[k], uop_pay_a[k], uop_pay_b[k]};
    endfunction

    // Stall: different window, ready low; nothing taken, outputs unchanged.
    task automatic stall_check();
        logic [37:0] saved [SLOTS];
        logic [2:0] saved_cnt;
        for (int k = 0; k < SLOTS; k++) saved[k] = slot_word(k);
        saved_cnt = uop_cnt;
        dn_ready = 1'b0;
        win_valid = '1;
        for (int i = 0; i < WIN; i++) begin
            win_cls[i] = (i % 2 == 0) ? 2'd1 : 2'd3;
            win_pay[i] = 16'hBEE0 + 16'(i);
        end
        #2;
        check("R7", "take_cnt while stalled", take_cnt, 0);
        @(posedge clk);
        @(negedge clk);
        check("R7", "uop_cnt hold", uop_cnt, saved_cnt);
        for (int k = 0; k < SLOTS; k++)
            check("R7", $sformatf("slot %0d hold", k), slot_word(k), saved[k]);
        dn_ready = 1'b1;
    endtask

    task automatic run_pattern(int code, int n, int tag);
        int cls [WIN];
        logic [PAY_W-1:0] pay [WIN];
        int p;
        int exp_take;
        int exp_uops;
        for (int i = 0; i < WIN; i++) begin
            cls[i] = (code >> (2 * i)) & 3;
            pay[i] = 16'((tag << 3) | i);
            win_cls[i] = 2'(cls[i]);
            win_pay[i] = pay[i];
            if (i < n) win_valid[i] = 1'b1;
            else if (i == n) win_valid[i] = 1'b0;
            else win_valid[i] = tag[0];
        end
        // Earliest fusible pair inside the valid prefix, -1 if none.
        p = -1;
        for (int i = 0; i + 1 < n; i++)
            if (p < 0 && (cls[i] == 1 || cls[i] == 2) && cls[i+1] == 3) p = i;
        exp_take = (p >= 0) ? n : ((n < SLOTS) ? n : SLOTS);
        exp_uops = (p >= 0) ? exp_take - 1 : exp_take;
        #2;
        check((n < WIN) ? "R1" : "R5", "take_cnt", take_cnt, exp_take);
        @(posedge clk);
        @(negedge clk);
        check("R9", "uop_cnt after edge", uop_cnt, exp_uops);
        for (int k = 0; k < SLOTS; k++) begin
            logic [37:0] e;
            string tg;
            int src;
            src = (p >= 0 && k > p) ? k + 1 : k;
            tg = "R2";
            if (k >= exp_uops) begin
                e = '0;
            end else if (k == p) begin
                e = {1'b1, 1'b1, 2'(cls[k]), pay[k], pay[k+1]};
                tg = "R4";
            end else begin
                e = {1'b1, 1'b0, 2'(cls[src]), pay[src], 16'h0};
                if (p >= 0 && k > p) tg = "R3";
                if (src == n - 1 && (cls[src] == 1 || cls[src] == 2)) tg = "R6";
            end
            check(tg, $sformatf("slot %0d code=%0h n=%0d", k, code, n), slot_word(k), e);
        end
    endtask

    initial begin
        rst = 1'b1;
        dn_ready = 1'b1;
        win_valid = '1;
        win_cls = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8", "uop_cnt in reset", uop_cnt, 0);
        for (int k = 0; k < SLOTS; k++)
            check("R8", $sformatf("slot %0d in reset", k), slot_word(k), 0);
        rst = 1'b0;
        for (int n = 0; n <= WIN; n++) begin
            for (int code = 0; code < 1024; code++) begin
                run_pattern(code, n, n * 1024 + code);
                if ((code % 101) == 7) stall_check();
            end
        end
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #5_000_000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule